// File: doc/BRIEF.md
# PWM Output Stage Start-Up and Mute Sequencer

This block decides when a PWM audio output stage may play. It watches two active-low enables, a chip reset and a power-down, along with a mute request and three serial-format selection pins. It drives one valid flag per channel and a hard-mute command to the modulator. While hard mute is asserted, the modulator holds each bridge in a quiet state: the positive leg low and the negative leg high. When the command drops, the stage enters normal differential PWM operation.

All timing is counted in master-clock cycles. If power-down is released first, a short initialization period follows. Reset must not be released until more than a minimum number of master-clock periods have passed since power-down was released; a reset released earlier is held back until that spacing has elapsed. If reset is released first, or both are released together, a longer initialization period applies. Once the block is operating, a change on any format pin restarts the long initialization. The mute request silences the output without a new initialization.

All inputs are taken as synchronous to the master clock, except the format pins, which get a two-stage synchronizer. The window lengths come from parameters for the clock rate in kHz, the two periods in milliseconds, and a divisor that shrinks them for simulation.

Top module: `pwm_startup_seq`

## Requirements
- R1: While `rst` is high, or after any clock edge at which `chip_rst_n` or `pwr_dn_n` is sampled low, `valid_l` and `valid_r` are 0 and `hard_mute` is 1.
- R2: Suppose `pwr_dn_n` is first sampled high at edge 0, `chip_rst_n` stays low until it is first sampled high at edge k, and k > MIN_GAP (16). Then initialization starts at edge k and the valid flags rise at edge k + SHORT_CYC.
- R3: Suppose `chip_rst_n` is released early, at an edge k with 1 <= k <= MIN_GAP after `pwr_dn_n`. Then the block stays off, initialization starts at edge MIN_GAP+1, and the valid flags rise at edge MIN_GAP+1+SHORT_CYC.
- R4: Suppose `chip_rst_n` is high before `pwr_dn_n`, or both are first sampled high at the same edge E. Then the valid flags rise at edge E + LONG_CYC.
- R5: During initialization the outputs stay muted. Sampling either enable low aborts the initialization. A later release starts a new timing window counted from that release.
- R6: In operation, `mute_req` sampled high clears both valid flags and sets `hard_mute` after that edge. Sampling it low again restores them after the next edge, without a new initialization.
- R7: In operation, a change on any bit of `fmt_pins` clears the valid flags at the third edge after the change. The valid flags return LONG_CYC edges after that.
- R8: A change on `fmt_pins` while initialization is in progress does not alter the time at which the valid flags rise.
- R9: `valid_l` always equals `valid_r`, and `hard_mute` is always their inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high system reset |
| chip_rst_n | input | 1 | Active-low chip reset request |
| pwr_dn_n | input | 1 | Active-low power-down request |
| mute_req | input | 1 | High requests hard mute while operating |
| fmt_pins | input | 3 | Serial-format selection pins, asynchronous |
| valid_l | output | 1 | Left channel valid flag |
| valid_r | output | 1 | Right channel valid flag |
| hard_mute | output | 1 | Hard-mute command to the modulator |

## Verification
A mute release and a format-pin restart can land on the same clock edge. The release would raise the valid flags at that edge, while the restart must keep them low. The bench provokes this by holding mute, flipping a format pin, and then dropping mute on exactly the edge where the synchronized change takes effect. It judges the result correct only if the flags stay low through that edge and rise exactly one long window later. The power-down-to-reset spacing is swept edge by edge across the boundary, and each release point is compared with the start time computed in the bench.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/mode_watch.sv
module mode_watch #(
  parameter int N_MODE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MODE-1:0] pins,
  output logic              changed
);
  logic [N_MODE-1:0] s1, s2, held;
  logic [N_MODE-1:0] diff;

  genvar g;
  generate
    for (g = 0; g < N_MODE; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          s1[g]   <= 1'b0;
          s2[g]   <= 1'b0;
          held[g] <= 1'b0;
        end else begin
          s1[g]   <= pins[g];
          s2[g]   <= s1[g];
          held[g] <= s2[g];
        end
      end
      assign diff[g] = s2[g] ^ held[g];
    end
  endgenerate

  assign changed = |diff;
endmodule

// File: rtl/order_tracker.sv
module order_tracker #(
  parameter int MIN_GAP = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_off,
  input  logic chip_rst_n,
  input  logic pwr_dn_n,
  output logic pdn_first,
  output logic gap_met
);
  localparam int GAP_MAX = MIN_GAP + 1;
  localparam int GW      = $clog2(GAP_MAX + 1);
  localparam logic [GW-1:0] GAP_TOP = GW'(GAP_MAX);

  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt   <= '0;
      pdn_first <= 1'b0;
    end else if (!pwr_dn_n) begin
      gap_cnt   <= '0;
      pdn_first <= 1'b0;
    end else begin
      if (in_off && gap_cnt != GAP_TOP)
        gap_cnt <= gap_cnt + 1'b1;
      if (in_off && !chip_rst_n)
        pdn_first <= 1'b1;
    end
  end

  assign gap_met = (gap_cnt == GAP_TOP);
endmodule

// File: rtl/init_timer.sv
module init_timer #(
  parameter int LONG_CYC  = 100,
  parameter int SHORT_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic sel_long,
  output logic expired
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= sel_long ? LONG_LD : SHORT_LD;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R2
  short_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !sel_long) |=> (cnt == SHORT_LD));
endmodule

// File: rtl/pwm_startup_seq.sv
module pwm_startup_seq #(
  parameter int CLK_KHZ  = 24576,
  parameter int LONG_MS  = 100,
  parameter int SHORT_MS = 5,
  parameter int TIME_DIV = 1,
  parameter int MIN_GAP  = 16,
  parameter int N_MODE   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_rst_n,
  input  logic              pwr_dn_n,
  input  logic              mute_req,
  input  logic [N_MODE-1:0] fmt_pins,
  output logic              valid_l,
  output logic              valid_r,
  output logic              hard_mute
);
  import pwm_seq_pkg::*;

  localparam int LONG_CYC  = CLK_KHZ * LONG_MS / TIME_DIV;
  localparam int SHORT_CYC = CLK_KHZ * SHORT_MS / TIME_DIV;

  seq_state_t state, state_n;
  logic both_up, mode_chg, pdn_first, gap_met, expired;
  logic t_load, t_long, play_n;

  assign both_up = chip_rst_n && pwr_dn_n;

  mode_watch #(.N_MODE(N_MODE)) u_mode (
    .clk(clk), .rst(rst), .pins(fmt_pins), .changed(mode_chg)
  );

  order_tracker #(.MIN_GAP(MIN_GAP)) u_order (
    .clk(clk), .rst(rst), .in_off(state == ST_OFF),
    .chip_rst_n(chip_rst_n), .pwr_dn_n(pwr_dn_n),
    .pdn_first(pdn_first), .gap_met(gap_met)
  );

  init_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .sel_long(t_long), .expired(expired)
  );

  always_comb begin
    state_n = state;
    t_load  = 1'b0;
    t_long  = 1'b1;
    case (state)
      ST_OFF: begin
        if (both_up) begin
          if (!pdn_first) begin
            state_n = ST_INIT;
            t_load  = 1'b1;
          end else if (gap_met) begin
            state_n = ST_INIT;
            t_load  = 1'b1;
            t_long  = 1'b0;
          end
        end
      end
      ST_INIT: begin
        if (!both_up)
          state_n = ST_OFF;
        else if (expired)
          state_n = ST_RUN;
      end
      ST_RUN: begin
        if (!both_up)
          state_n = ST_OFF;
        else if (mode_chg) begin
          state_n = ST_INIT;
          t_load  = 1'b1;
        end
      end
      default: state_n = ST_OFF;
    endcase
  end

  assign play_n = (state_n == ST_RUN) && !mute_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      valid_l   <= 1'b0;
      valid_r   <= 1'b0;
      hard_mute <= 1'b1;
    end else begin
      state     <= state_n;
      valid_l   <= play_n;
      valid_r   <= play_n;
      hard_mute <= !play_n;
    end
  end

  // R1
  off_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (!chip_rst_n || !pwr_dn_n) |=> (!valid_l && hard_mute));

  // R3
  early_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFF && both_up && pdn_first && !gap_met) |=> (state == ST_OFF));

  // R4
  long_init_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFF && both_up && !pdn_first) |=> (state == ST_INIT && !expired));

  // R6
  mute_drop_chk: assert property (@(posedge clk) disable iff (rst)
    mute_req |=> (!valid_l && !valid_r && hard_mute));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && both_up && mode_chg) |=> (state == ST_INIT));

  // R9
  pair_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_l == valid_r) && (hard_mute == !valid_l));
endmodule

// File: tb/tb_pwm_startup_seq.sv
module tb_pwm_startup_seq;
  localparam int CLK_KHZ  = 1000;
  localparam int LONG_MS  = 100;
  localparam int SHORT_MS = 5;
  localparam int TIME_DIV = 1000;
  localparam int MIN_GAP  = 16;
  localparam int LONG     = CLK_KHZ * LONG_MS / TIME_DIV;
  localparam int SHORT    = CLK_KHZ * SHORT_MS / TIME_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_rst_n = 1'b0;
  logic pwr_dn_n = 1'b0;
  logic mute_req = 1'b0;
  logic [2:0] fmt_pins = 3'b000;
  logic valid_l, valid_r, hard_mute;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  pwm_startup_seq #(
    .CLK_KHZ(CLK_KHZ), .LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS),
    .TIME_DIV(TIME_DIV), .MIN_GAP(MIN_GAP), .N_MODE(3)
  ) dut (
    .clk(clk), .rst(rst), .chip_rst_n(chip_rst_n), .pwr_dn_n(pwr_dn_n),
    .mute_req(mute_req), .fmt_pins(fmt_pins),
    .valid_l(valid_l), .valid_r(valid_r), .hard_mute(hard_mute)
  );

  always #5 clk = ~clk;

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_on(input bit on, input string tag);
    vectors++;
    if (valid_l !== on || valid_r !== on || hard_mute !== !on) begin
      miscompares++;
      $display("FAIL %s: valid_l=%b valid_r=%b hard_mute=%b, expected valid=%b hard_mute=%b",
               tag, valid_l, valid_r, hard_mute, on, !on);
    end
  endtask

  task automatic go_off();
    chip_rst_n = 1'b0;
    pwr_dn_n   = 1'b0;
    wait_edges(1);
    expect_on(1'b0, "R1 off after enables low");
    wait_edges(1);
  endtask

  // pdn released, k edges later reset released
  task automatic pdn_then_rst(input int k);
    int e;
    go_off();
    pwr_dn_n = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk);
    chip_rst_n = 1'b1;
    e = (k > MIN_GAP) ? k : MIN_GAP + 1;
    wait_edges(e + SHORT - k);
    expect_on(1'b0, (k > MIN_GAP) ? "R2 before short window" : "R3 before held-back window");
    wait_edges(1);
    expect_on(1'b1, (k > MIN_GAP) ? "R2 short window end" : "R3 held-back window end");
  endtask

  initial begin
    wait_edges(2);
    expect_on(1'b0, "R1 during system reset");
    rst = 1'b0;
    wait_edges(3);
    expect_on(1'b0, "R1 after reset, enables low");

    for (int k = 1; k <= 24; k++) pdn_then_rst(k);

    // R4 simultaneous release
    go_off();
    chip_rst_n = 1'b1;
    pwr_dn_n   = 1'b1;
    wait_edges(LONG);
    expect_on(1'b0, "R4 simultaneous before long end");
    wait_edges(1);
    expect_on(1'b1, "R4 simultaneous long end");

    // R4 reset first
    for (int d = 1; d <= 3; d++) begin
      go_off();
      chip_rst_n = 1'b1;
      repeat (d) @(posedge clk);
      @(negedge clk);
      pwr_dn_n = 1'b1;
      wait_edges(LONG);
      expect_on(1'b0, "R4 reset first before long end");
      wait_edges(1);
      expect_on(1'b1, "R4 reset first long end");
    end

    // R6 mute without re-init
    mute_req = 1'b1;
    wait_edges(1);
    expect_on(1'b0, "R6 mute drops valid");
    wait_edges(3);
    expect_on(1'b0, "R6 mute held");
    mute_req = 1'b0;
    wait_edges(1);
    expect_on(1'b1, "R6 unmute restores at once");

    // R7 each format pin
    for (int b = 0; b < 3; b++) begin
      fmt_pins[b] = ~fmt_pins[b];
      wait_edges(2);
      expect_on(1'b1, "R7 still on before sync delay");
      wait_edges(1);
      expect_on(1'b0, "R7 restart drops valid");
      wait_edges(LONG - 1);
      expect_on(1'b0, "R7 before long restart end");
      wait_edges(1);
      expect_on(1'b1, "R7 long restart end");
    end

    // R7 coincidence: unmute on the restart edge
    mute_req = 1'b1;
    wait_edges(1);
    expect_on(1'b0, "R6 mute before coincidence");
    fmt_pins[1] = ~fmt_pins[1];
    wait_edges(2);
    mute_req = 1'b0;
    wait_edges(1);
    expect_on(1'b0, "R7 restart wins over unmute");
    wait_edges(LONG - 1);
    expect_on(1'b0, "R7 coincidence before long end");
    wait_edges(1);
    expect_on(1'b1, "R7 coincidence long end");

    // R8 format change during init
    go_off();
    pwr_dn_n = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chip_rst_n = 1'b1;
    wait_edges(1);
    expect_on(1'b0, "R8 init entered");
    fmt_pins[2] = ~fmt_pins[2];
    wait_edges(4);
    expect_on(1'b0, "R8 before short end");
    wait_edges(1);
    expect_on(1'b1, "R8 short end unchanged");
    wait_edges(3);
    expect_on(1'b1, "R8 no late restart");

    // R5 abort during long init
    go_off();
    chip_rst_n = 1'b1;
    pwr_dn_n   = 1'b1;
    wait_edges(40);
    pwr_dn_n = 1'b0;
    wait_edges(1);
    expect_on(1'b0, "R5 abort muted");
    pwr_dn_n = 1'b1;
    wait_edges(60);
    expect_on(1'b0, "R5 old window ignored");
    wait_edges(40);
    expect_on(1'b0, "R5 before new long end");
    wait_edges(1);
    expect_on(1'b1, "R5 new long end");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule